// File: doc/BRIEF.md
# Indexed Colour Palette Front End

This block is the register-mapped front end of a colour lookup table that feeds a video DAC. It stores 256 palette entries of 8-bit red, green and blue. A host reaches it through four 32-bit word registers. A pixel stream on the video side turns 8-bit pixel indices into 24-bit colours.

To load the palette, the host writes an entry index to the index register. It then writes the three components of that entry, red first and blue last, to the palette data register. An internal component counter routes each write to the right component. The full entry is stored only when blue arrives. After blue, the index moves on to the next entry, so a run of entries can be streamed without setting the index again. Reads of the palette data register walk the components in the same order.

A small bank of indirect control registers is reached through the same index register and a separate control data register. One control register masks pixel indices before the lookup. Another holds the cursor enables, which appear on an output pin.

The pixel port is a valid-only stream with no back-pressure. Every pixel presented with `pix_valid` gives exactly one result, marked by `rgb_valid`, on the following cycle. The block never stalls, and the downstream consumer must always accept a result.

Top module: `clut_front`

## Requirements
- R1: After reset, the index is 0 and the component counter points at red. All palette entries are zero and `rgb_valid` is low. The control registers hold 0xFF at index 0x04, 0x00 at 0x05, 0x73 at 0x06 and 0x00 at 0x07.
- R2: Every 8-bit value travels in bits [31:24] of the bus word. Bits [23:0] are ignored on write and read as zero.
- R3: A write to the index register (`reg_sel`=0) loads the index and returns the component counter to red.
- R4: Three writes to the palette data register (`reg_sel`=1) supply red, then green, then blue. The entry is stored as {red,green,blue} only on the blue write. A lookup made before the blue write returns the old entry.
- R5: After each blue access, the index increments by one, wrapping from 255 to 0, and the counter returns to red.
- R6: Reads of the palette data register return red, then green, then blue of the entry at the index, and advance the counter and index exactly as writes do. If a read and a write occur in the same cycle, the write takes effect and the read has no side effect.
- R7: The control data register (`reg_sel`=2) reads and writes the indirect register selected by the index when that index is 0x04 to 0x07. At any other index, writes are ignored and reads return zero.
- R8: `cursor_on` equals bits [1:0] of indirect register 0x06. Clearing those bits turns `cursor_on` off.
- R9: A pixel accepted with `pix_valid` gives `rgb_valid` high on the next cycle. The colour returned is the entry at (`pix_idx` AND register 0x04). `rgb_valid` is low on every other cycle.
- R10: The cursor word (`reg_sel`=3) ignores writes and reads as zero.
- R11: Reading the index register returns the current index in bits [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Word select: 0 index, 1 palette data, 2 control data, 3 cursor |
| reg_wdata | input | 32 | Write data, byte in [31:24] |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high, zero otherwise |
| pix_valid | input | 1 | Pixel index present |
| pix_idx | input | 8 | Pixel index |
| rgb_valid | output | 1 | Colour result present |
| rgb | output | 24 | Colour {red,green,blue} |
| cursor_on | output | 2 | Cursor enables from indirect register 0x06 |

## Verification
The hardest case to reach from the ports is a half-written entry at the index wrap. Here a lookup must still see the old colour between the green and blue writes, and the following red write must land in entry 0. The stimulus sets the index to 255 and streams six components. It issues a pixel lookup of the same entry between green and blue, then reads back both entries and the index. A random phase then mixes bus accesses at random indices with pixel lookups under a narrowed plane mask. A behavioural model checks every cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {COMP_R = 2'd0, COMP_G = 2'd1, COMP_B = 2'd2} comp_e;
  typedef enum logic [1:0] {SEL_IDX = 2'd0, SEL_PAL = 2'd1, SEL_CTL = 2'd2, SEL_CUR = 2'd3} sel_e;

  // power-up value of indirect control register k (k counted from the bank base)
  function automatic logic [7:0] ctl_reset(int k);
    case (k)
      0: ctl_reset = 8'hFF;
      2: ctl_reset = 8'h73;
      default: ctl_reset = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_idx,
  input  logic [IW-1:0]   new_idx,
  input  logic            step,
  input  logic            load,
  input  logic [CW-1:0]   din,
  output logic [IW-1:0]   idx,
  output comp_e           comp,
  output logic            wr_en,
  output logic [3*CW-1:0] wr_data
);
  logic [CW-1:0] hold_r, hold_g;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      comp   <= COMP_R;
      hold_r <= '0;
      hold_g <= '0;
    end else if (set_idx) begin
      idx  <= new_idx;
      comp <= COMP_R;
    end else if (step) begin
      case (comp)
        COMP_R: begin
          if (load) hold_r <= din;
          comp <= COMP_G;
        end
        COMP_G: begin
          if (load) hold_g <= din;
          comp <= COMP_B;
        end
        default: begin
          comp <= COMP_R;
          idx  <= idx + 1'b1;
        end
      endcase
    end
  end

  assign wr_en   = step && load && (comp == COMP_B);
  assign wr_data = {hold_r, hold_g, din};
endmodule

// File: rtl/clut_ctrl_regs.sv
module clut_ctrl_regs
  import clut_pkg::*;
#(
  parameter int IW    = 8,
  parameter int CW    = 8,
  parameter int BASE  = 4,
  parameter int COUNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          wr,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout,
  output logic [CW-1:0] plane_mask,
  output logic [1:0]    cursor_en
);
  localparam int MASK_SLOT = 0;
  localparam int CURS_SLOT = 2;

  logic [CW-1:0] regs [COUNT];
  logic          hit;
  logic [IW-1:0] off;

  assign hit = (idx >= IW'(BASE)) && (idx < IW'(BASE + COUNT));
  assign off = idx - IW'(BASE);

  for (genvar k = 0; k < COUNT; k++) begin : g_reg
    logic [CW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= CW'(ctl_reset(k));
      else if (wr && hit && off == IW'(k)) q <= din;
    end
    assign regs[k] = q;
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < COUNT; k++)
      if (hit && off == IW'(k)) dout = regs[k];
  end

  assign plane_mask = regs[MASK_SLOT];
  assign cursor_en  = regs[CURS_SLOT][1:0];
endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   waddr,
  input  logic [3*CW-1:0] wdata,
  input  logic [IW-1:0]   host_addr,
  output logic [3*CW-1:0] host_data,
  input  logic            look_valid,
  input  logic [IW-1:0]   look_addr,
  output logic            out_valid,
  output logic [3*CW-1:0] out_data
);
  localparam int DEPTH = 1 << IW;

  logic [3*CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= look_valid;
      if (look_valid) out_data <= mem[look_addr];
    end
  end

  assign host_data = mem[host_addr];
endmodule

// File: rtl/clut_front.sv
module clut_front
  import clut_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            pix_valid,
  input  logic [IW-1:0]   pix_idx,
  output logic            rgb_valid,
  output logic [3*CW-1:0] rgb,
  output logic [1:0]      cursor_on
);
  localparam int LANE_LO = DW - CW;

  logic [CW-1:0]   lane;
  logic [IW-1:0]   idx;
  comp_e           comp;
  logic            pal_we;
  logic [3*CW-1:0] pal_wdata, pal_host;
  logic [CW-1:0]   ctl_dout, plane_mask;
  logic            pal_acc, idx_wr, ctl_wr;
  logic [CW-1:0]   rd_byte;

  assign lane    = reg_wdata[DW-1:LANE_LO];
  assign idx_wr  = reg_wr && (reg_sel == SEL_IDX);
  assign ctl_wr  = reg_wr && (reg_sel == SEL_CTL);
  assign pal_acc = (reg_wr || reg_rd) && (reg_sel == SEL_PAL);

  clut_seq #(.IW(IW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .set_idx(idx_wr), .new_idx(IW'(lane)),
    .step(pal_acc), .load(reg_wr), .din(lane), .idx(idx), .comp(comp),
    .wr_en(pal_we), .wr_data(pal_wdata)
  );

  clut_ctrl_regs #(.IW(IW), .CW(CW), .BASE(4), .COUNT(4)) u_ctl (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr(ctl_wr), .din(lane),
    .dout(ctl_dout), .plane_mask(plane_mask), .cursor_en(cursor_on)
  );

  clut_ram #(.IW(IW), .CW(CW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(idx), .wdata(pal_wdata),
    .host_addr(idx), .host_data(pal_host),
    .look_valid(pix_valid), .look_addr(pix_idx & IW'(plane_mask)),
    .out_valid(rgb_valid), .out_data(rgb)
  );

  always_comb begin
    case (reg_sel)
      SEL_IDX: rd_byte = CW'(idx);
      SEL_PAL: begin
        case (comp)
          COMP_R:  rd_byte = pal_host[3*CW-1 -: CW];
          COMP_G:  rd_byte = pal_host[2*CW-1 -: CW];
          default: rd_byte = pal_host[CW-1:0];
        endcase
      end
      SEL_CTL: rd_byte = ctl_dout;
      default: rd_byte = '0;
    endcase
  end

  assign reg_rdata = reg_rd ? {rd_byte, {LANE_LO{1'b0}}} : '0;
endmodule

// File: rtl/clut_front_chk.sv
module clut_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        pix_valid,
  input logic        rgb_valid,
  input logic [1:0]  cursor_on,
  input logic [7:0]  idx,
  input logic [1:0]  comp
);
  AST_RGB_FOLLOWS_PIX: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |=> rgb_valid); // R9
  AST_RGB_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |=> !rgb_valid); // R9
  AST_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |-> reg_rdata[23:0] == 24'h0); // R2
  AST_CURSOR_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_sel == 2'd3) |-> reg_rdata == 32'h0); // R10
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_sel == 2'd0) |=> (comp == 2'd0 && idx == $past(reg_wdata[31:24]))); // R3
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_sel == 2'd1 && comp == 2'd2) |=> (idx == 8'($past(idx) + 8'd1) && comp == 2'd0)); // R5
  AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_sel == 2'd2) |=> $stable(cursor_on)); // R8
endmodule

bind clut_front clut_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
  .rgb_valid(rgb_valid), .cursor_on(cursor_on), .idx(idx), .comp(comp)
);

// File: tb/clut_front_test.sv
module clut_front_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = 8'h0;
  logic        rgb_valid;
  logic [23:0] rgb;
  logic [1:0]  cursor_on;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_front uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .rgb_valid(rgb_valid), .rgb(rgb), .cursor_on(cursor_on)
  );

  // behavioural reference model
  logic [23:0] m_pal [256];
  logic [7:0]  m_ctl [8];
  logic [7:0]  m_idx, m_hr, m_hg;
  int          m_comp;
  logic        m_vld;
  logic [23:0] m_rgb;

  task automatic m_reset();
    for (int i = 0; i < 256; i++) m_pal[i] = 24'h0;
    for (int i = 0; i < 8; i++) m_ctl[i] = 8'h0;
    m_ctl[4] = 8'hFF; m_ctl[6] = 8'h73;
    m_idx = 0; m_comp = 0; m_hr = 0; m_hg = 0; m_vld = 0; m_rgb = 0;
  endtask

  task automatic m_advance(input bit wr, input logic [7:0] d);
    if (m_comp == 0) begin if (wr) m_hr = d; m_comp = 1; end
    else if (m_comp == 1) begin if (wr) m_hg = d; m_comp = 2; end
    else begin
      if (wr) m_pal[m_idx] = {m_hr, m_hg, d};
      m_comp = 0; m_idx = m_idx + 8'd1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [7:0] d;
      d = reg_wdata[31:24];
      if (pix_valid) m_rgb = m_pal[pix_idx & m_ctl[4]];
      m_vld = pix_valid;
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin m_idx = d; m_comp = 0; end
          2'd1: m_advance(1'b1, d);
          2'd2: if (m_idx >= 4 && m_idx <= 7) m_ctl[m_idx[2:0]] = d;
          default: ;
        endcase
      end else if (reg_rd && reg_sel == 2'd1) m_advance(1'b0, 8'h0);
    end
  end

  function automatic logic [31:0] m_exp(input logic [1:0] sel);
    logic [7:0] b;
    case (sel)
      2'd0: b = m_idx;
      2'd1: b = (m_comp == 0) ? m_pal[m_idx][23:16] : (m_comp == 1) ? m_pal[m_idx][15:8] : m_pal[m_idx][7:0];
      2'd2: b = (m_idx >= 4 && m_idx <= 7) ? m_ctl[m_idx[2:0]] : 8'h0;
      default: b = 8'h0;
    endcase
    return {b, 24'h0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rgb_valid == m_vld, "R9 valid", 32'(rgb_valid), 32'(m_vld));
      if (m_vld) check(rgb == m_rgb, "R9 colour", 32'(rgb), 32'(m_rgb));
      check(cursor_on == m_ctl[6][1:0], "R8 cursor", 32'(cursor_on), 32'(m_ctl[6][1:0]));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 32'h0;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    reg_rd = 1; reg_sel = sel;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
    check(m_exp(sel) == exp, {tag, " model"}, m_exp(sel), exp);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pix_chk(input logic [7:0] p, input logic [23:0] exp, input string tag);
    pix_valid = 1; pix_idx = p;
    @(negedge clk);
    pix_valid = 0;
    check(rgb_valid && rgb == exp, tag, 32'(rgb), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rgb_valid == 1'b0, "R1 rgb_valid", 32'(rgb_valid), 32'h0);
    rd_chk(2'd0, 32'h00000000, "R1 index");
    rd_chk(2'd1, 32'h00000000, "R1 palette");
    wr(2'd0, 32'h04000000); rd_chk(2'd2, 32'hFF000000, "R1 ctl04");
    wr(2'd0, 32'h05000000); rd_chk(2'd2, 32'h00000000, "R1 ctl05");
    wr(2'd0, 32'h06000000); rd_chk(2'd2, 32'h73000000, "R1 ctl06");
    check(cursor_on == 2'b11, "R8 initial", 32'(cursor_on), 32'h3);
    wr(2'd0, 32'h07000000); rd_chk(2'd2, 32'h00000000, "R1 ctl07");
    // R2 / R11: low lanes ignored, index read back
    wr(2'd0, 32'h05ABCDEF); rd_chk(2'd0, 32'h05000000, "R2 R11 index");
    wr(2'd2, 32'h5A123456); rd_chk(2'd2, 32'h5A000000, "R2 ctl lane");
    // R3: index write restarts the component counter
    wr(2'd0, 32'h0A000000); wr(2'd1, 32'h11000000);
    wr(2'd0, 32'h0A000000);
    wr(2'd1, 32'h22000000); wr(2'd1, 32'h33000000); wr(2'd1, 32'h44000000);
    pix_chk(8'h0A, 24'h223344, "R3 restart");
    // R4: commit only on blue
    wr(2'd0, 32'h14000000); wr(2'd1, 32'hA1000000); wr(2'd1, 32'hB2000000);
    pix_chk(8'h14, 24'h000000, "R4 before blue");
    wr(2'd1, 32'hC3000000);
    pix_chk(8'h14, 24'hA1B2C3, "R4 after blue");
    // R5: wrap 255 -> 0 with lookup between green and blue
    wr(2'd0, 32'hFF000000); wr(2'd1, 32'h01000000); wr(2'd1, 32'h02000000);
    pix_chk(8'hFF, 24'h000000, "R5 half entry");
    wr(2'd1, 32'h03000000);
    rd_chk(2'd0, 32'h00000000, "R5 wrap index");
    wr(2'd1, 32'h04000000); wr(2'd1, 32'h05000000); wr(2'd1, 32'h06000000);
    pix_chk(8'hFF, 24'h010203, "R5 entry 255");
    pix_chk(8'h00, 24'h040506, "R5 entry 0");
    rd_chk(2'd0, 32'h01000000, "R5 next index");
    // R6: readback order and advance
    wr(2'd0, 32'hFF000000);
    rd_chk(2'd1, 32'h01000000, "R6 red");
    rd_chk(2'd1, 32'h02000000, "R6 green");
    rd_chk(2'd1, 32'h03000000, "R6 blue");
    rd_chk(2'd1, 32'h04000000, "R6 next red");
    // R7: out-of-bank indirect indices
    wr(2'd0, 32'h08000000); wr(2'd2, 32'h77000000); rd_chk(2'd2, 32'h00000000, "R7 idx8");
    wr(2'd0, 32'h03000000); wr(2'd2, 32'h77000000); rd_chk(2'd2, 32'h00000000, "R7 idx3");
    wr(2'd0, 32'h07000000); wr(2'd2, 32'h3C000000); rd_chk(2'd2, 32'h3C000000, "R7 idx7");
    // R10: cursor word
    wr(2'd3, 32'hFFFFFFFF); rd_chk(2'd3, 32'h00000000, "R10 cursor word");
    // R9: plane mask applied
    wr(2'd0, 32'h04000000); wr(2'd2, 32'h0F000000);
    pix_chk(8'hFA, 24'h223344, "R9 mask");
    // R8: clearing cursor bits
    wr(2'd0, 32'h06000000); wr(2'd2, 32'h70000000);
    check(cursor_on == 2'b00, "R8 cleared", 32'(cursor_on), 32'h0);
    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 5);
      pix_valid = $urandom_range(0, 1); pix_idx = 8'($urandom);
      case (op)
        0: wr(2'd0, {8'($urandom_range(0, 15)), 24'($urandom)});
        1: wr(2'd1, $urandom);
        2: wr(2'd2, $urandom);
        3: rd_chk(2'd1, m_exp(2'd1), "R6 random");
        4: rd_chk(2'd2, m_exp(2'd2), "R7 random");
        default: rd_chk(2'd0, m_exp(2'd0), "R11 random");
      endcase
    end
    pix_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule